// File: doc/BRIEF.md
# Multi-Context ADC Conversion Sequencer

This block drives a 16-input analog-to-digital converter on behalf of up to three request contexts: one real-time context, started by a hardware pulse, and two software contexts, each started by a register write. Each context has its own channel-select mask and its own averaging mask. When a context is accepted, the sequencer converts every selected channel once, from the lowest channel index up. For each channel it runs a start/done handshake with the converter, repeated four times and averaged when that channel's averaging bit is set. Each result goes into a result register. The real-time context has its own results; the two software contexts share one set.

A host uses a byte-wide register port with combinational read data and a one-cycle write strobe. It powers the block on, programs the masks and starts a software context. It then either polls that context's control register for busy and end-of-conversion, or waits on one of two interrupt lines. Each line has its own status register, with one bit per context cleared by writing 1, and its own mask register, so two host processors can each service their own contexts.

Sequencer states: IDLE (waits for a pending context while powered), SCAN (picks the lowest remaining channel, or ends), LAUNCH (one-cycle start pulse), WAIT (collects a sample on done), STORE (writes the result), FINISH (posts end-of-conversion and interrupt status). Transitions: IDLE→SCAN on a pending context while powered; SCAN→LAUNCH while channels remain; SCAN→FINISH when none remain; LAUNCH→WAIT; WAIT→LAUNCH on done with samples still owed; WAIT→STORE on done of the last sample; STORE→SCAN; FINISH→IDLE.

Top module: `adc_seq_top`

## Requirements
- R1: After reset every register reads 0, both interrupt lines are low and no conversion start is issued.
- R2: Writing a control byte with bit 5 set (0x12 for software context 1, 0x13 for software context 2) starts a conversion of that context's selected channels, one start pulse per sample, in ascending channel order. The select mask is a 16-bit LSB/MSB pair at 0x02/0x03 (real-time), 0x06/0x07 (software 1) and 0x0A/0x0B (software 2), and bit i selects channel i.
- R3: A result is stored left-justified in a 16-bit pair: the 10-bit value occupies bits 15:6, the LSB byte is at base+2*i and the MSB byte at base+2*i+1. The base is 0x37 for the software contexts and 0x17 for the real-time context.
- R4: A channel whose averaging bit is set takes four consecutive samples and stores the floor of their mean, which is correct up to full scale. The averaging masks are LSB/MSB pairs at 0x04, 0x08 and 0x0C for the real-time, software 1 and software 2 contexts.
- R5: In a control register, bit 0 reads 1 while that context is pending or converting and bit 1 reads 1 once its results are stored. End-of-conversion clears when a new start is accepted.
- R6: A start for a context that is already busy is ignored and causes no extra conversion.
- R7: While the power bit (register 0x00, bit 0) is clear, starts from both the register port and the real-time pin are ignored.
- R8: When several contexts are pending, they are served in the order real-time, software 1, software 2.
- R9: When a context finishes, bit 0, 1 or 2 (real-time, software 1, software 2) is set in both status registers (0x0E for line A, 0x10 for line B). Writing 1 to a status bit clears it. Each line is high while any status bit is set whose bit in that line's mask register (0x0F for A, 0x11 for B) is clear.
- R10: A one-cycle pulse on rt_req starts the real-time context, whose results land at base 0x17.
- R11: A context started with an empty select mask finishes without any conversion and still sets end-of-conversion and its status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| rt_req | input | 1 | Real-time context start pulse |
| conv_chan | output | 4 | Channel index for the converter |
| conv_start | output | 1 | Start one sample, one cycle |
| conv_done | input | 1 | Sample ready, one cycle |
| conv_sample | input | 10 | Sample value, valid with conv_done |
| irq_a | output | 1 | Interrupt line A |
| irq_b | output | 1 | Interrupt line B |

## Verification
A wrong sequencer state shows up at the converter interface within a cycle or two. It appears as a missing or doubled start pulse, a channel index that changes during a sample, or a channel order that breaks ascending or priority order, and the bench logs every start to detect these. A wrong accumulator or sample count shows up only when the result bytes are read after the context finishes: an averaged channel near full scale exposes overflow, and a left-justification error moves bits between the two bytes. Errors in pending, end-of-conversion or status bookkeeping show up at the next control-register read or as an interrupt-line level in the cycle after completion or after a status or mask write.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_SCAN, ST_LAUNCH, ST_WAIT, ST_STORE, ST_FINISH
    } seq_state_t;

    localparam int NCTX    = 3;
    localparam int CTX_RT  = 0;
    localparam int CTX_SW1 = 1;

    localparam int ADDR_PWR     = 8'h00;
    localparam int ADDR_SEL0    = 8'h02;  // + 4*ctx
    localparam int ADDR_AVG0    = 8'h04;  // + 4*ctx
    localparam int ADDR_ISR_A   = 8'h0E;
    localparam int ADDR_IMR_A   = 8'h0F;
    localparam int ADDR_ISR_B   = 8'h10;
    localparam int ADDR_IMR_B   = 8'h11;
    localparam int ADDR_CTRL1   = 8'h12;  // + (ctx - 1)
    localparam int ADDR_RES_RT  = 8'h17;
    localparam int ADDR_RES_SW  = 8'h37;
    localparam int START_BIT    = 5;
endpackage

// File: rtl/adc_seq_lowbit.sv
module adc_seq_lowbit #(
    parameter int W  = 16,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int NCH  = 16,
    parameter int SMPW = 10,
    localparam int CHW = $clog2(NCH),
    localparam int CXW = $clog2(NCTX)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      pwr_on,
    input  logic [NCTX-1:0]           pend,
    input  logic [NCTX-1:0][NCH-1:0]  sel,
    input  logic [NCTX-1:0][NCH-1:0]  avg,
    output logic                      accept,
    output logic [CXW-1:0]            pick_ctx,
    output logic [CXW-1:0]            ctx,
    output logic                      active,
    output logic [CHW-1:0]            conv_chan,
    output logic                      conv_start,
    input  logic                      conv_done,
    input  logic [SMPW-1:0]           conv_sample,
    output logic                      res_we,
    output logic [SMPW-1:0]           res_val,
    output logic                      fin
);
    seq_state_t state, nxt;
    logic [NCH-1:0]  work_q, avgm_q;
    logic [CHW-1:0]  ch_q;
    logic [2:0]      left_q;
    logic            use_avg_q;
    logic [SMPW+1:0] acc_q;
    logic [CXW-1:0]  ctx_q;
    logic            pend_any, work_any;
    logic [CHW-1:0]  next_ch;
    logic            go;

    adc_seq_lowbit #(.W(NCTX)) u_ctx_pick (.vec(pend),   .found(pend_any), .idx(pick_ctx));
    adc_seq_lowbit #(.W(NCH))  u_ch_pick  (.vec(work_q), .found(work_any), .idx(next_ch));

    assign go = pend_any && pwr_on;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (go) nxt = ST_SCAN;
            ST_SCAN:   nxt = work_any ? ST_LAUNCH : ST_FINISH;
            ST_LAUNCH: nxt = ST_WAIT;
            ST_WAIT:   if (conv_done) nxt = (left_q == 3'd1) ? ST_STORE : ST_LAUNCH;
            ST_STORE:  nxt = ST_SCAN;
            ST_FINISH: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            work_q    <= '0;
            avgm_q    <= '0;
            ch_q      <= '0;
            left_q    <= '0;
            use_avg_q <= 1'b0;
            acc_q     <= '0;
            ctx_q     <= '0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && go) begin
                ctx_q  <= pick_ctx;
                work_q <= sel[pick_ctx];
                avgm_q <= avg[pick_ctx];
            end
            if (state == ST_SCAN && work_any) begin
                ch_q            <= next_ch;
                work_q[next_ch] <= 1'b0;
                use_avg_q       <= avgm_q[next_ch];
                left_q          <= avgm_q[next_ch] ? 3'd4 : 3'd1;
                acc_q           <= '0;
            end
            if (state == ST_WAIT && conv_done) begin
                acc_q  <= acc_q + (SMPW+2)'(conv_sample);
                left_q <= left_q - 3'd1;
            end
        end
    end

    always_comb begin
        accept     = (state == ST_IDLE) && go;
        active     = (state != ST_IDLE);
        conv_start = (state == ST_LAUNCH);
        conv_chan  = ch_q;
        res_we     = (state == ST_STORE);
        res_val    = use_avg_q ? acc_q[SMPW+1:2] : acc_q[SMPW-1:0];
        fin        = (state == ST_FINISH);
        ctx        = ctx_q;
    end
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
    import adc_seq_pkg::*;
#(
    parameter int NCH  = 16,
    parameter int SMPW = 10,
    parameter int AW   = 8,
    localparam int CHW  = $clog2(NCH),
    localparam int CXW  = $clog2(NCTX),
    localparam int PADW = 16 - SMPW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   reg_addr,
    input  logic [7:0]      reg_wdata,
    input  logic            reg_wr,
    output logic [7:0]      reg_rdata,
    input  logic            rt_req,
    output logic [CHW-1:0]  conv_chan,
    output logic            conv_start,
    input  logic            conv_done,
    input  logic [SMPW-1:0] conv_sample,
    output logic            irq_a,
    output logic            irq_b
);
    logic                     pwr_q;
    logic [NCTX-1:0]          imr_a, imr_b, isr_a, isr_b, pend_q, eoc_q, ctx_busy;
    logic [NCTX-1:0][NCH-1:0] sel_all, avg_all;
    logic [SMPW-1:0]          res_rt [NCH];
    logic [SMPW-1:0]          res_sw [NCH];
    logic                     seq_accept, seq_active, seq_res_we, seq_fin;
    logic [CXW-1:0]           seq_pick, seq_ctx;
    logic [SMPW-1:0]          seq_res_val;

    adc_seq_fsm #(.NCH(NCH), .SMPW(SMPW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .pwr_on(pwr_q), .pend(pend_q),
        .sel(sel_all), .avg(avg_all), .accept(seq_accept), .pick_ctx(seq_pick),
        .ctx(seq_ctx), .active(seq_active), .conv_chan(conv_chan),
        .conv_start(conv_start), .conv_done(conv_done), .conv_sample(conv_sample),
        .res_we(seq_res_we), .res_val(seq_res_val), .fin(seq_fin)
    );

    for (genvar k = 0; k < NCTX; k++) begin : g_ctx
        logic [NCH-1:0] sel_r, avg_r;
        logic           pend_r, eoc_r, ia_r, ib_r, start_req;
        if (k == CTX_RT) begin : g_rt
            assign start_req = rt_req;
        end else begin : g_sw
            assign start_req = reg_wr && reg_wdata[START_BIT] &&
                               (reg_addr == AW'(ADDR_CTRL1 + k - 1));
        end
        assign ctx_busy[k] = pend_r | (seq_active && seq_ctx == CXW'(k));
        assign sel_all[k]  = sel_r;
        assign avg_all[k]  = avg_r;
        assign pend_q[k]   = pend_r;
        assign eoc_q[k]    = eoc_r;
        assign isr_a[k]    = ia_r;
        assign isr_b[k]    = ib_r;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sel_r <= '0; avg_r <= '0; pend_r <= 1'b0;
                eoc_r <= 1'b0; ia_r <= 1'b0; ib_r <= 1'b0;
            end else begin
                if (reg_wr && reg_addr == AW'(ADDR_SEL0 + 4*k))     sel_r[7:0]  <= reg_wdata;
                if (reg_wr && reg_addr == AW'(ADDR_SEL0 + 4*k + 1)) sel_r[15:8] <= reg_wdata;
                if (reg_wr && reg_addr == AW'(ADDR_AVG0 + 4*k))     avg_r[7:0]  <= reg_wdata;
                if (reg_wr && reg_addr == AW'(ADDR_AVG0 + 4*k + 1)) avg_r[15:8] <= reg_wdata;
                if (start_req && pwr_q && !ctx_busy[k]) begin
                    pend_r <= 1'b1;
                    eoc_r  <= 1'b0;
                end else if (seq_accept && seq_pick == CXW'(k)) begin
                    pend_r <= 1'b0;
                end
                if (seq_fin && seq_ctx == CXW'(k)) begin
                    eoc_r <= 1'b1;
                    ia_r  <= 1'b1;
                    ib_r  <= 1'b1;
                end else begin
                    if (reg_wr && reg_addr == AW'(ADDR_ISR_A) && reg_wdata[k]) ia_r <= 1'b0;
                    if (reg_wr && reg_addr == AW'(ADDR_ISR_B) && reg_wdata[k]) ib_r <= 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr_q <= 1'b0;
            imr_a <= '0;
            imr_b <= '0;
            for (int i = 0; i < NCH; i++) begin
                res_rt[i] <= '0;
                res_sw[i] <= '0;
            end
        end else begin
            if (reg_wr && reg_addr == AW'(ADDR_PWR))   pwr_q <= reg_wdata[0];
            if (reg_wr && reg_addr == AW'(ADDR_IMR_A)) imr_a <= reg_wdata[NCTX-1:0];
            if (reg_wr && reg_addr == AW'(ADDR_IMR_B)) imr_b <= reg_wdata[NCTX-1:0];
            if (seq_res_we) begin
                if (seq_ctx == CXW'(CTX_RT)) res_rt[conv_chan] <= seq_res_val;
                else                         res_sw[conv_chan] <= seq_res_val;
            end
        end
    end

    logic [AW-1:0] off_rt, off_sw;
    logic [15:0]   wide_rt, wide_sw;
    assign off_rt  = reg_addr - AW'(ADDR_RES_RT);
    assign off_sw  = reg_addr - AW'(ADDR_RES_SW);
    assign wide_rt = {res_rt[off_rt[CHW:1]], {PADW{1'b0}}};
    assign wide_sw = {res_sw[off_sw[CHW:1]], {PADW{1'b0}}};

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == AW'(ADDR_PWR))   reg_rdata[0] = pwr_q;
        if (reg_addr == AW'(ADDR_ISR_A)) reg_rdata[NCTX-1:0] = isr_a;
        if (reg_addr == AW'(ADDR_IMR_A)) reg_rdata[NCTX-1:0] = imr_a;
        if (reg_addr == AW'(ADDR_ISR_B)) reg_rdata[NCTX-1:0] = isr_b;
        if (reg_addr == AW'(ADDR_IMR_B)) reg_rdata[NCTX-1:0] = imr_b;
        for (int k = 0; k < NCTX; k++) begin
            if (reg_addr == AW'(ADDR_SEL0 + 4*k))     reg_rdata = sel_all[k][7:0];
            if (reg_addr == AW'(ADDR_SEL0 + 4*k + 1)) reg_rdata = sel_all[k][15:8];
            if (reg_addr == AW'(ADDR_AVG0 + 4*k))     reg_rdata = avg_all[k][7:0];
            if (reg_addr == AW'(ADDR_AVG0 + 4*k + 1)) reg_rdata = avg_all[k][15:8];
            if (k != CTX_RT && reg_addr == AW'(ADDR_CTRL1 + k - 1))
                reg_rdata = {6'b0, eoc_q[k], ctx_busy[k]};
        end
        if (reg_addr >= AW'(ADDR_RES_RT) && reg_addr < AW'(ADDR_RES_RT + 2*NCH))
            reg_rdata = off_rt[0] ? wide_rt[15:8] : wide_rt[7:0];
        if (reg_addr >= AW'(ADDR_RES_SW) && reg_addr < AW'(ADDR_RES_SW + 2*NCH))
            reg_rdata = off_sw[0] ? wide_sw[15:8] : wide_sw[7:0];
    end

    assign irq_a = |(isr_a & ~imr_a);
    assign irq_b = |(isr_b & ~imr_b);
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
    parameter int CHW  = 4,
    parameter int NCTX = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            conv_start,
    input logic [CHW-1:0]  conv_chan,
    input logic [NCTX-1:0] busy,
    input logic [NCTX-1:0] eoc,
    input logic            active,
    input logic            pwr,
    input logic            fin,
    input logic            reg_wr,
    input logic            irq_a,
    input logic            irq_b
);
    // R2: exactly one start pulse per sample, and the channel held meanwhile
    a_r2_single_start: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);
    a_r2_chan_hold: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> $stable(conv_chan));
    // R5: a context is never both busy and complete
    a_r5_eoc_busy_excl: assert property (@(posedge clk) disable iff (!rst_n)
        (eoc & busy) == '0);
    // R7: the sequencer leaves idle only after power was on
    a_r7_power_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> $past(pwr));
    // R9: an interrupt line rises only after a completion or a register write
    a_r9_irq_a_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_a) |-> $past(fin || reg_wr));
    a_r9_irq_b_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_b) |-> $past(fin || reg_wr));
endmodule

bind adc_seq_top adc_seq_chk #(.CHW(CHW), .NCTX(adc_seq_pkg::NCTX)) u_chk (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_chan(conv_chan),
    .busy(ctx_busy), .eoc(eoc_q), .active(seq_active), .pwr(pwr_q),
    .fin(seq_fin), .reg_wr(reg_wr), .irq_a(irq_a), .irq_b(irq_b)
);

// File: tb/adc_seq_top_test.sv
module adc_seq_top_test;
    logic       clk = 0, rst_n = 0;
    logic [7:0] reg_addr = 0, reg_wdata = 0, reg_rdata;
    logic       reg_wr = 0, rt_req = 0;
    logic [3:0] conv_chan;
    logic       conv_start, conv_done = 0, irq_a, irq_b;
    logic [9:0] conv_sample = 0;

    int checks = 0, failures = 0;
    int base [16];
    int lastsamp [16];
    int log_ch [256];
    int nlog = 0, sidx = 0, mbusy = 0, mch = 0;

    always #5 clk = ~clk;

    adc_seq_top uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rdata(reg_rdata), .rt_req(rt_req),
        .conv_chan(conv_chan), .conv_start(conv_start), .conv_done(conv_done),
        .conv_sample(conv_sample), .irq_a(irq_a), .irq_b(irq_b)
    );

    // converter model: two-cycle latency, sample = base + (global index mod 4)
    always @(negedge clk) begin
        conv_done = 0;
        if (!rst_n) begin
            mbusy = 0;
        end else if (mbusy > 0) begin
            mbusy--;
            if (mbusy == 0) begin
                conv_sample = 10'(base[mch] + (sidx % 4));
                lastsamp[mch] = base[mch] + (sidx % 4);
                sidx++;
                conv_done = 1;
            end
        end else if (conv_start) begin
            mch = int'(conv_chan);
            mbusy = 2;
            if (nlog < 256) log_ch[nlog] = mch;
            nlog++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, output int d);
        @(negedge clk);
        reg_addr = a;
        #1 d = int'(reg_rdata);
    endtask

    task automatic wait_idle(input logic [7:0] ctrl);
        int d;
        for (int i = 0; i < 3000; i++) begin
            rd(ctrl, d);
            if ((d & 1) == 0) break;
        end
    endtask

    task automatic chk_res(input string req, input logic [7:0] rbase, input int ch, input int v);
        int lo, hi;
        rd(8'(rbase + 2*ch), lo);
        rd(8'(rbase + 2*ch + 1), hi);
        chk(req, lo, (v & 3) << 6);
        chk(req, hi, v >> 2);
    endtask

    task automatic t_reset();
        int d;
        rd(8'h00, d); chk("R1 power", d, 0);
        rd(8'h02, d); chk("R1 sel", d, 0);
        rd(8'h12, d); chk("R1 ctrl", d, 0);
        rd(8'h0E, d); chk("R1 isr", d, 0);
        rd(8'h37, d); chk("R1 result", d, 0);
        chk("R1 irq", int'(irq_a | irq_b), 0);
        chk("R1 start", int'(conv_start), 0);
    endtask

    task automatic t_basic();
        int d, n0;
        wr(8'h00, 8'h01);
        wr(8'h06, 8'h21); wr(8'h07, 8'h84);
        n0 = nlog;
        wr(8'h12, 8'h20);
        rd(8'h12, d); chk("R5 busy", d & 1, 1);
        wait_idle(8'h12);
        rd(8'h12, d); chk("R5 eoc", d, 2);
        chk("R2 count", nlog - n0, 4);
        chk("R2 order0", log_ch[n0], 0);
        chk("R2 order1", log_ch[n0+1], 5);
        chk("R2 order2", log_ch[n0+2], 10);
        chk("R2 order3", log_ch[n0+3], 15);
        chk_res("R3 ch5", 8'h37, 5, lastsamp[5]);
        chk_res("R3 ch15", 8'h37, 15, lastsamp[15]);
    endtask

    task automatic t_avg();
        int n0;
        wr(8'h0A, 8'h06); wr(8'h0C, 8'h04);
        n0 = nlog;
        wr(8'h13, 8'h20);
        wait_idle(8'h13);
        chk("R4 samples", nlog - n0, 5);
        chk_res("R4 averaged full scale", 8'h37, 2, base[2] + 1);
        chk_res("R4 single", 8'h37, 1, lastsamp[1]);
    endtask

    task automatic t_busy();
        int d, n0;
        wr(8'h06, 8'h01); wr(8'h07, 8'h00);
        n0 = nlog;
        wr(8'h12, 8'h20);
        rd(8'h12, d); chk("R5 eoc cleared on start", d, 1);
        wr(8'h12, 8'h20);
        wait_idle(8'h12);
        repeat (10) @(negedge clk);
        chk("R6 ignored restart", nlog - n0, 1);
    endtask

    task automatic t_power();
        int d, n0;
        wr(8'h00, 8'h00);
        n0 = nlog;
        wr(8'h12, 8'h20);
        @(negedge clk); rt_req = 1; @(negedge clk); rt_req = 0;
        repeat (20) @(negedge clk);
        rd(8'h12, d); chk("R7 no busy", d, 2);
        chk("R7 no conversion", nlog - n0, 0);
        wr(8'h00, 8'h01);
        repeat (10) @(negedge clk);
        chk("R7 nothing queued", nlog - n0, 0);
    endtask

    task automatic t_priority();
        int n0;
        wr(8'h02, 8'h00); wr(8'h03, 8'h02);
        wr(8'h0A, 8'h20); wr(8'h0B, 8'h00); wr(8'h0C, 8'h00);
        n0 = nlog;
        @(negedge clk); rt_req = 1; @(negedge clk); rt_req = 0;
        wr(8'h13, 8'h20);
        wr(8'h12, 8'h20);
        wait_idle(8'h13);
        chk("R8 count", nlog - n0, 3);
        chk("R8 rt first", log_ch[n0], 9);
        chk("R8 sw1 second", log_ch[n0+1], 0);
        chk("R8 sw2 third", log_ch[n0+2], 5);
        chk_res("R10 rt result", 8'h17, 9, lastsamp[9]);
    endtask

    task automatic t_irq();
        int d;
        rd(8'h0E, d); chk("R9 status A", d, 7);
        chk("R9 irq_a", int'(irq_a), 1);
        wr(8'h0F, 8'h07);
        #1 chk("R9 masked irq_a", int'(irq_a), 0);
        rd(8'h0E, d); chk("R9 status kept", d, 7);
        wr(8'h0E, 8'h02);
        rd(8'h0E, d); chk("R9 w1c", d, 5);
        wr(8'h0E, 8'h05); wr(8'h0F, 8'h00);
        rd(8'h0E, d); chk("R9 cleared", d, 0);
        chk("R9 irq_b", int'(irq_b), 1);
        wr(8'h10, 8'h07);
        #1 chk("R9 irq_b low", int'(irq_b), 0);
        wr(8'h11, 8'h06);
        wr(8'h12, 8'h20);
        wait_idle(8'h12);
        rd(8'h10, d); chk("R9 status B", d, 2);
        chk("R9 irq_b masked", int'(irq_b), 0);
    endtask

    task automatic t_empty();
        int d, n0;
        wr(8'h0A, 8'h00); wr(8'h0B, 8'h00);
        n0 = nlog;
        wr(8'h13, 8'h20);
        wait_idle(8'h13);
        rd(8'h13, d); chk("R11 eoc", d, 2);
        chk("R11 no conversion", nlog - n0, 0);
        rd(8'h0E, d); chk("R11 status", d & 4, 4);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) base[i] = i * 37 + 5;
        base[2] = 1020;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_avg();
        t_busy();
        t_power();
        t_priority();
        t_irq();
        t_empty();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule